// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides, cycle by cycle, which operations an on-chip flash array may perform: ordinary memory reads, verify reads, programming and erasing. Software selects program mode or erase mode through a small control register, and chooses erase targets through a block-select register. Both registers sit behind a simple write/read bus port. The programming algorithm, the cell timing and the real fault detectors sit outside the block. A detected fault reaches it as a single-cycle pulse.

A fault during program or erase mode sets a sticky error flag and moves the block into an error-protect state. In that state reads and verify reads stay open, while program and erase stay locked until a reset or a hardware standby. The flag survives software standby. Entering software standby in the middle of a program or erase operation is itself treated as a fault. An interrupt-mask request, which covers the non-maskable interrupt as well, stays raised for as long as either mode bit is held. This applies even in error-protect.

Top module: `flashguard_ctrl`

## Requirements
- R1: Reset (`rst_n`) and hardware standby (`hw_stby_n`) are synchronous and active low. At any clock edge where either is low, the block clears the mode bits, the block-select register and the error flag, sets every output to 0 and returns the state to normal. The first edge after both are high loads the normal permissions.
- R2: With the error flag clear and no software standby active, `perm_read`, `perm_verify`, `perm_prog` and `perm_erase` are all 1.
- R3: The control register is at address 0. Bit 0 is the program-mode bit and bit 1 is the erase-mode bit. A write with only bit 0 set enters program mode, a write with only bit 1 set enters erase mode, and a write with neither set returns to normal. A write with both bits set leaves the register and the mode unchanged.
- R4: An `err_pulse` in program or erase mode sets the error flag and enters error-protect with the mode bits kept. The error flag reads back as bit DATA_W-1 of address 0, which is bit 7 by default. An `err_pulse` in normal mode has no effect. An error pulse wins over a control write in the same cycle.
- R5: In error-protect, `perm_read` and `perm_verify` are 1, while `perm_prog`, `perm_erase`, `prog_active` and `erase_active` are 0. Writes of the mode bits are still stored and read back.
- R6: A software-standby entry in program or erase mode sets the error flag, clears the mode bits and the block-select register, and enters error-protect standby, where every output is 0. This entry takes priority over an `err_pulse` in the same cycle.
- R7: A software-standby entry in error-protect clears the mode bits and the block-select register and keeps the error flag. A release then returns to error-protect with the flag still 1.
- R8: A software-standby entry in normal mode clears the registers, leaves the error flag at 0 and sets every output to 0. A release returns to normal permissions.
- R9: In either standby state, bus writes to either register are ignored.
- R10: Software cannot change the error flag. Writing bit 7 has no effect, and only the R1 conditions clear the flag.
- R11: The block-select register is at address 1, low BLK_W bits. `erase_blocks` equals that register while `erase_active` is 1 and is 0 otherwise.
- R12: `irq_mask` equals (program bit OR erase bit) one edge after the register changes. `prog_active` is 1 when in program mode with the program bit set, and `erase_active` is 1 when in erase mode with the erase bit set. All outputs are registered and lag the state by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby_n | input | 1 | Hardware standby, active low, same effect as reset |
| sw_stby_enter | input | 1 | Pulse: enter software standby |
| sw_stby_release | input | 1 | Pulse: leave software standby |
| err_pulse | input | 1 | Pulse: fault detected during program or erase |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 block select) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| perm_read | output | 1 | Memory read allowed |
| perm_verify | output | 1 | Verify read allowed |
| perm_prog | output | 1 | Programming allowed |
| perm_erase | output | 1 | Erasing allowed |
| prog_active | output | 1 | Program operation enabled on the array |
| erase_active | output | 1 | Erase operation enabled on the array |
| irq_mask | output | 1 | Request to mask all interrupts, including the non-maskable one |
| erase_blocks | output | BLK_W | Blocks selected for an active erase |

## Verification
The control register is driven with program-only, erase-only, both-set and cleared patterns. These patterns separate a correct mode decode from one that accepts an illegal combination or keys on the wrong bit. Fault pulses are applied in normal, program and erase modes, which shows whether the error entry is limited to active operations. Software-standby entry and release are tried from normal, program and error-protect. This distinguishes the three exit paths and shows whether the error flag persists or is wrongly cleared. Writes during error-protect and standby, a direct write to the flag bit, and concurrent standby-plus-fault pulses expose wrong priorities and a flag that software can change.

// File: rtl/flashguard_pkg.sv
package flashguard_pkg;

   typedef enum logic [2:0] {
      FG_NORMAL  = 3'd0,
      FG_PROG    = 3'd1,
      FG_ERASE   = 3'd2,
      FG_ERRPROT = 3'd3,
      FG_ERRSTBY = 3'd4,
      FG_STBY    = 3'd5
   } fg_state_e;

   typedef struct packed {
      logic rd;
      logic vf;
      logic pg;
      logic er;
      logic pact;
      logic eact;
      logic irq;
   } fg_perm_s;

   localparam int FG_P_BIT = 0;
   localparam int FG_E_BIT = 1;

endpackage

// File: rtl/fg_fsm.sv
module fg_fsm
   import flashguard_pkg::*;
(
   input  logic      clk,
   input  logic      hold,
   input  logic      sw_enter,
   input  logic      sw_release,
   input  logic      err_pulse,
   input  logic      ctrl_wr,
   input  logic      wr_p,
   input  logic      wr_e,
   output fg_state_e state_q,
   output logic      clear_regs,
   output logic      set_err,
   output logic      ctrl_we,
   output logic      bus_ok
);

   fg_state_e state_d;
   logic      in_stby;
   logic      pe_mode;

   assign in_stby = (state_q == FG_ERRSTBY) || (state_q == FG_STBY);
   assign pe_mode = (state_q == FG_PROG) || (state_q == FG_ERASE);

   always_comb begin
      state_d    = state_q;
      clear_regs = 1'b0;
      set_err    = 1'b0;
      ctrl_we    = 1'b0;
      bus_ok     = !in_stby;
      if (in_stby) begin
         if (sw_release) begin
            state_d = (state_q == FG_ERRSTBY) ? FG_ERRPROT : FG_NORMAL;
         end
      end else if (sw_enter) begin
         clear_regs = 1'b1;
         bus_ok     = 1'b0;
         if (pe_mode) begin
            set_err = 1'b1;
            state_d = FG_ERRSTBY;
         end else if (state_q == FG_ERRPROT) begin
            state_d = FG_ERRSTBY;
         end else begin
            state_d = FG_STBY;
         end
      end else if (err_pulse && pe_mode) begin
         set_err = 1'b1;
         state_d = FG_ERRPROT;
      end else if (ctrl_wr && !(wr_p && wr_e)) begin
         ctrl_we = 1'b1;
         if (state_q != FG_ERRPROT) begin
            if (wr_p)      state_d = FG_PROG;
            else if (wr_e) state_d = FG_ERASE;
            else           state_d = FG_NORMAL;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (hold) state_q <= FG_NORMAL;
      else      state_q <= state_d;
   end

   // R6
   stby_err_chk: assert property (@(posedge clk) disable iff (hold)
      (((state_q == FG_PROG) || (state_q == FG_ERASE)) && sw_enter) |=> (state_q == FG_ERRSTBY));

   // R4
   err_entry_chk: assert property (@(posedge clk) disable iff (hold)
      (((state_q == FG_PROG) || (state_q == FG_ERASE)) && err_pulse && !sw_enter)
      |=> (state_q == FG_ERRPROT));

   // R8
   stby_exit_chk: assert property (@(posedge clk) disable iff (hold)
      ((state_q == FG_STBY) && sw_release) |=> (state_q == FG_NORMAL));

endmodule

// File: rtl/fg_regs.sv
module fg_regs #(
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             hold,
   input  logic             clear_regs,
   input  logic             set_err,
   input  logic             ctrl_we,
   input  logic             wr_p,
   input  logic             wr_e,
   input  logic             blk_we,
   input  logic [BLK_W-1:0] blk_wdata,
   output logic             p_q,
   output logic             e_q,
   output logic             err_q,
   output logic [BLK_W-1:0] blk_q
);

   always_ff @(posedge clk) begin
      if (hold)         err_q <= 1'b0;
      else if (set_err) err_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (hold || clear_regs) begin
         p_q <= 1'b0;
         e_q <= 1'b0;
      end else if (ctrl_we) begin
         p_q <= wr_p;
         e_q <= wr_e;
      end
   end

   always_ff @(posedge clk) begin
      if (hold || clear_regs) blk_q <= '0;
      else if (blk_we)        blk_q <= blk_wdata;
   end

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (hold)
      err_q |=> err_q);

   // R3
   pe_excl_chk: assert property (@(posedge clk) disable iff (hold)
      !(p_q && e_q));

endmodule

// File: rtl/fg_outs.sv
module fg_outs
   import flashguard_pkg::*;
#(
   parameter int BLK_W = 8
) (
   input  logic             clk,
   input  logic             hold,
   input  fg_state_e        state_q,
   input  logic             p_q,
   input  logic             e_q,
   input  logic [BLK_W-1:0] blk_q,
   output fg_perm_s         perm_q,
   output logic [BLK_W-1:0] eblk_q
);

   fg_perm_s         perm_d;
   logic [BLK_W-1:0] eblk_d;
   logic             open_st;
   logic             clean_st;

   assign open_st  = (state_q != FG_ERRSTBY) && (state_q != FG_STBY);
   assign clean_st = (state_q == FG_NORMAL) || (state_q == FG_PROG) || (state_q == FG_ERASE);

   always_comb begin
      perm_d.rd   = open_st;
      perm_d.vf   = open_st;
      perm_d.pg   = clean_st;
      perm_d.er   = clean_st;
      perm_d.pact = (state_q == FG_PROG) && p_q;
      perm_d.eact = (state_q == FG_ERASE) && e_q;
      perm_d.irq  = p_q || e_q;
   end

   for (genvar i = 0; i < BLK_W; i++) begin : g_eblk
      assign eblk_d[i] = perm_d.eact & blk_q[i];
   end

   always_ff @(posedge clk) begin
      if (hold) begin
         perm_q <= '0;
         eblk_q <= '0;
      end else begin
         perm_q <= perm_d;
         eblk_q <= eblk_d;
      end
   end

   // R5
   errprot_lock_chk: assert property (@(posedge clk) disable iff (hold)
      (state_q == FG_ERRPROT) |=> (!perm_q.pg && !perm_q.er && !perm_q.pact && !perm_q.eact
                                   && perm_q.rd && perm_q.vf));

   // R12
   irq_track_chk: assert property (@(posedge clk) disable iff (hold)
      1'b1 |=> (perm_q.irq == $past(p_q || e_q)));

endmodule

// File: rtl/flashguard_ctrl.sv
module flashguard_ctrl
   import flashguard_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BLK_W     = 8,
   parameter int ADDR_W    = 2,
   parameter int CTRL_ADDR = 0,
   parameter int BLK_ADDR  = 1,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby_n,
   input  logic              sw_stby_enter,
   input  logic              sw_stby_release,
   input  logic              err_pulse,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              perm_read,
   output logic              perm_verify,
   output logic              perm_prog,
   output logic              perm_erase,
   output logic              prog_active,
   output logic              erase_active,
   output logic              irq_mask,
   output logic [BLK_W-1:0]  erase_blocks
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] BLK_A  = ADDR_W'(BLK_ADDR);
   localparam int                ERR_BIT = DATA_W - 1;

   if (DATA_W < 3) begin : g_bad_data
      $error("DATA_W must leave room for two mode bits and the error flag");
   end
   if ((BLK_W < 1) || (BLK_W > DATA_W)) begin : g_bad_blk
      $error("BLK_W must lie between 1 and DATA_W");
   end
   if ((CTRL_ADDR == BLK_ADDR) || (CTRL_ADDR >= (1 << ADDR_W)) || (BLK_ADDR >= (1 << ADDR_W))) begin : g_bad_addr
      $error("register addresses must be distinct and fit in ADDR_W");
   end

   logic             hold;
   fg_state_e        state_q;
   logic             clear_regs, set_err, ctrl_we, bus_ok;
   logic             ctrl_wr, blk_we;
   logic             wr_p, wr_e;
   logic             p_q, e_q, err_q;
   logic [BLK_W-1:0] blk_q;
   fg_perm_s         perm_q;
   logic [DATA_W-1:0] rdata_d;

   assign hold    = !rst_n || !hw_stby_n;
   assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);
   assign blk_we  = bus_wr && (bus_addr == BLK_A) && bus_ok;
   assign wr_p    = bus_wdata[FG_P_BIT];
   assign wr_e    = bus_wdata[FG_E_BIT];

   fg_fsm u_fsm (
      .clk        (clk),
      .hold       (hold),
      .sw_enter   (sw_stby_enter),
      .sw_release (sw_stby_release),
      .err_pulse  (err_pulse),
      .ctrl_wr    (ctrl_wr),
      .wr_p       (wr_p),
      .wr_e       (wr_e),
      .state_q    (state_q),
      .clear_regs (clear_regs),
      .set_err    (set_err),
      .ctrl_we    (ctrl_we),
      .bus_ok     (bus_ok)
   );

   fg_regs #(.BLK_W(BLK_W)) u_regs (
      .clk        (clk),
      .hold       (hold),
      .clear_regs (clear_regs),
      .set_err    (set_err),
      .ctrl_we    (ctrl_we),
      .wr_p       (wr_p),
      .wr_e       (wr_e),
      .blk_we     (blk_we),
      .blk_wdata  (bus_wdata[BLK_W-1:0]),
      .p_q        (p_q),
      .e_q        (e_q),
      .err_q      (err_q),
      .blk_q      (blk_q)
   );

   fg_outs #(.BLK_W(BLK_W)) u_outs (
      .clk     (clk),
      .hold    (hold),
      .state_q (state_q),
      .p_q     (p_q),
      .e_q     (e_q),
      .blk_q   (blk_q),
      .perm_q  (perm_q),
      .eblk_q  (erase_blocks)
   );

   assign perm_read    = perm_q.rd;
   assign perm_verify  = perm_q.vf;
   assign perm_prog    = perm_q.pg;
   assign perm_erase   = perm_q.er;
   assign prog_active  = perm_q.pact;
   assign erase_active = perm_q.eact;
   assign irq_mask     = perm_q.irq;

   always_comb begin
      rdata_d = '0;
      if (bus_addr == CTRL_A) begin
         rdata_d[FG_P_BIT] = p_q;
         rdata_d[FG_E_BIT] = e_q;
         rdata_d[ERR_BIT]  = err_q;
      end else if (bus_addr == BLK_A) begin
         rdata_d[BLK_W-1:0] = blk_q;
      end
   end

   if (REG_RDATA) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (hold) bus_rdata <= '0;
         else      bus_rdata <= rdata_d;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rdata_d;
   end

   // R3
   pe_reject_chk: assert property (@(posedge clk) disable iff (hold)
      (ctrl_wr && wr_p && wr_e && !sw_stby_enter) |=> $stable({p_q, e_q}));

   // R9
   stby_blk_chk: assert property (@(posedge clk) disable iff (hold)
      (((state_q == FG_STBY) || (state_q == FG_ERRSTBY)) && bus_wr) |=> $stable(blk_q));

endmodule

// File: tb/flashguard_ctrl_bench.sv
`timescale 1ns/1ps
module flashguard_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby_n = 1'b1;
   logic       sw_stby_enter = 1'b0;
   logic       sw_stby_release = 1'b0;
   logic       err_pulse = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       perm_read, perm_verify, perm_prog, perm_erase;
   logic       prog_active, erase_active, irq_mask;
   logic [7:0] erase_blocks;

   int total = 0;
   int fails = 0;

   always #4 clk = ~clk;

   flashguard_ctrl u_flashguard_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .hw_stby_n       (hw_stby_n),
      .sw_stby_enter   (sw_stby_enter),
      .sw_stby_release (sw_stby_release),
      .err_pulse       (err_pulse),
      .bus_wr          (bus_wr),
      .bus_addr        (bus_addr),
      .bus_wdata       (bus_wdata),
      .bus_rdata       (bus_rdata),
      .perm_read       (perm_read),
      .perm_verify     (perm_verify),
      .perm_prog       (perm_prog),
      .perm_erase      (perm_erase),
      .prog_active     (prog_active),
      .erase_active    (erase_active),
      .irq_mask        (irq_mask),
      .erase_blocks    (erase_blocks)
   );

   // ops: 0 idle, 1 write, 2 standby enter, 3 standby release, 4 fault pulse
   // perm bits: {read, verify, prog, erase, prog_active, erase_active, irq_mask}
   // fields: op(3) addr(2) data(8) perm(7) ctrl readback(8) req(4)
   localparam logic [31:0] VECS [0:13] = '{
      {3'd0, 2'd0, 8'h00, 7'b1111000, 8'h00, 4'd2},   // R2 normal
      {3'd1, 2'd0, 8'h01, 7'b1111101, 8'h01, 4'd3},   // R3 program mode
      {3'd1, 2'd0, 8'h02, 7'b1111011, 8'h02, 4'd3},   // R3 erase mode
      {3'd1, 2'd0, 8'h03, 7'b1111011, 8'h02, 4'd3},   // R3 both set ignored
      {3'd1, 2'd0, 8'h00, 7'b1111000, 8'h00, 4'd3},   // R3 back to normal
      {3'd4, 2'd0, 8'h00, 7'b1111000, 8'h00, 4'd4},   // R4 fault in normal ignored
      {3'd1, 2'd0, 8'h01, 7'b1111101, 8'h01, 4'd12},  // R12 mask follows P
      {3'd4, 2'd0, 8'h00, 7'b1100001, 8'h81, 4'd4},   // R4 fault in program
      {3'd1, 2'd0, 8'h00, 7'b1100000, 8'h80, 4'd5},   // R5 write in error-protect
      {3'd1, 2'd0, 8'h02, 7'b1100001, 8'h82, 4'd5},   // R5 E stored, not active
      {3'd1, 2'd0, 8'h00, 7'b1100000, 8'h80, 4'd10},  // R10 flag not cleared by write
      {3'd2, 2'd0, 8'h00, 7'b0000000, 8'h80, 4'd7},   // R7 standby from error-protect
      {3'd1, 2'd0, 8'h01, 7'b0000000, 8'h80, 4'd9},   // R9 write in standby ignored
      {3'd3, 2'd0, 8'h00, 7'b1100000, 8'h80, 4'd7}    // R7 release to error-protect
   };

   function automatic string req_name(input logic [3:0] k);
      case (k)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd7:    return "R7";
         4'd9:    return "R9";
         4'd10:   return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] perms();
      return {perm_read, perm_verify, perm_prog, perm_erase, prog_active, erase_active, irq_mask};
   endfunction

   task automatic apply(input logic [2:0] op, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      case (op)
         3'd1: begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
         3'd2: sw_stby_enter = 1'b1;
         3'd3: sw_stby_release = 1'b1;
         3'd4: err_pulse = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      bus_wr = 1'b0; sw_stby_enter = 1'b0; sw_stby_release = 1'b0; err_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_state(input string req, input logic [6:0] ep, input logic [7:0] ec);
      bus_addr = 2'd0;
      #1;
      check(req, 32'(perms()), 32'(ep));
      check(req, 32'(bus_rdata), 32'(ec));
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin : main
      // R1 outputs and registers clear during reset
      repeat (3) @(negedge clk);
      check_state("R1", 7'b0000000, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1", 7'b1111000, 8'h00);

      for (int i = 0; i < 14; i++) begin
         apply(VECS[i][31:29], VECS[i][28:27], VECS[i][26:19]);
         check_state(req_name(VECS[i][3:0]), VECS[i][18:12], VECS[i][11:4]);
      end

      // R1 hardware standby clears the sticky flag
      @(negedge clk); hw_stby_n = 1'b0;
      @(negedge clk);
      check_state("R1", 7'b0000000, 8'h00);
      hw_stby_n = 1'b1;
      @(negedge clk);
      check_state("R1", 7'b1111000, 8'h00);

      // R10 flag bit not writable in normal mode
      apply(3'd1, 2'd0, 8'h80);
      check_state("R10", 7'b1111000, 8'h00);

      // R12 mask lags register by one edge
      @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h01;
      @(negedge clk); bus_wr = 1'b0;
      #1;
      check("R12", 32'(bus_rdata), 32'h01);
      check("R12", 32'(irq_mask), 32'h0);
      @(negedge clk);
      check("R12", 32'(irq_mask), 32'h1);

      // R6 standby entry while programming, with a concurrent fault
      @(negedge clk); sw_stby_enter = 1'b1; err_pulse = 1'b1;
      @(negedge clk); sw_stby_enter = 1'b0; err_pulse = 1'b0;
      @(negedge clk);
      check_state("R6", 7'b0000000, 8'h80);
      apply(3'd3, 2'd0, 8'h00);
      check_state("R7", 7'b1100000, 8'h80);
      pulse_reset();
      check_state("R1", 7'b1111000, 8'h00);

      // R4 fault in erase mode keeps E and the mask
      apply(3'd1, 2'd0, 8'h02);
      apply(3'd4, 2'd0, 8'h00);
      check_state("R4", 7'b1100001, 8'h82);
      pulse_reset();

      // R8 standby from normal, R9 writes ignored there
      apply(3'd1, 2'd1, 8'h3C);
      apply(3'd2, 2'd0, 8'h00);
      check_state("R8", 7'b0000000, 8'h00);
      apply(3'd1, 2'd1, 8'hFF);
      bus_addr = 2'd1; #1;
      check("R9", 32'(bus_rdata), 32'h00);
      apply(3'd1, 2'd0, 8'h02);
      check_state("R9", 7'b0000000, 8'h00);
      apply(3'd3, 2'd0, 8'h00);
      check_state("R8", 7'b1111000, 8'h00);

      // R11 block selection only during active erase
      apply(3'd1, 2'd1, 8'hA5);
      bus_addr = 2'd1; #1;
      check("R11", 32'(bus_rdata), 32'hA5);
      check("R11", 32'(erase_blocks), 32'h00);
      apply(3'd1, 2'd0, 8'h02);
      check("R11", 32'(erase_blocks), 32'hA5);
      apply(3'd1, 2'd0, 8'h01);
      check("R11", 32'(erase_blocks), 32'h00);
      apply(3'd1, 2'd0, 8'h00);
      check_state("R2", 7'b1111000, 8'h00);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule